// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block moves outgoing frames from memory to a byte stream by walking a circular list of transmit descriptors. Each descriptor takes eight bytes and holds two little-endian 32-bit words. The word at offset 0 is the buffer address. The word at offset 4 holds the flags. Software prepares a descriptor and then clears its hand-off bit, which passes the descriptor to the engine. Software then writes the start command. The engine reads descriptors one after another and streams each buffer's bytes out. When a buffer is fully sent, the engine writes the flags word back with the hand-off bit set, which returns the descriptor to software.

Flags bit 30 marks the last descriptor of the ring, so the ring needs no entry count. After that descriptor the engine goes back to the queue base address. Flags bit 15 marks the buffer that ends a frame, and the low bits of the flags word give the buffer length in bytes. Descriptor and buffer reads and the write-back all go through one request/response memory port. That port has one read outstanding at a time. Frame bytes leave on a valid/ready stream, and a last marker is raised on the final byte of each frame.

Top module: `txr_dma`

## Requirements
- R1: After reset, and while transmit is disabled (control bit 3 clear), the engine raises no memory request and no stream byte.
- R2: A control write with both bit 9 and bit 3 set starts the engine. Its first memory access is a read of the flags word at queue base + 4.
- R3: When the engine reads a flags word with bit 31 set, it stops. It streams no byte for that descriptor and writes nothing back.
- R4: A buffer's bytes leave in address order, least significant byte of each 32-bit word first. The count of bytes equals flags bits [13:0].
- R5: tx_last is 1 only on the final byte of a buffer whose flags bit 15 is set. It is 0 on every other byte, including the last byte of a buffer that does not end a frame.
- R6: Once all of a buffer's bytes are accepted, the engine writes the flags word back to descriptor + 4. Bit 31 is set in that write and every other bit is unchanged.
- R7: After a descriptor with flags bit 30 set, the next descriptor read is at the queue base. Otherwise it is at the current descriptor + 8.
- R8: After a write-back, the engine goes straight on to the next descriptor without a new start command.
- R9: If a start command arrives while the engine is busy, it is held. When the engine next meets a descriptor with bit 31 set, it reads that flags word once more before stopping.
- R10: Writing the control register with bit 3 clear aborts any transfer within two cycles, with no write-back. It also returns the descriptor pointer to the queue base, so the next start begins there.
- R11: A descriptor with length 0 sends no byte but is still written back with bit 31 set.
- R12: A memory request holds its address, direction and data until mem_ready. A stream byte holds its data and last marker until tx_ready.
- R13: Register writes to any offset other than control (0x000) and queue base (0x01C) have no effect.
- R14: A control write with bit 9 set but bit 3 clear does not start the engine.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the current request |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | Stream sink accepts the byte |

## Verification
Some properties are checked by assertions on every cycle:
- memory requests and stream bytes hold still under back-pressure;
- every write-back targets a flags word and carries the hand-off bit;
- the last marker only appears on a valid byte;
- a disabled engine stays silent with its pointer parked on the base.

Other behaviour can only be shown by the bench's scenarios:
- byte order;
- frame-end placement across multi-buffer frames;
- the return to base after a wrap descriptor;
- the extra re-read caused by a start that arrives mid-run;
- an abort that leaves the descriptor unreturned;
- decoding of ignored register writes.

// File: rtl/txr_pkg.sv
// Package: shared constants and state encoding for the transmit ring engine.
// Assumes descriptor and control bit positions are fixed by the software
// interface and must not move.
package txr_pkg;
    localparam int OWN_BIT        = 31;  // 1 = descriptor belongs to software
    localparam int WRAP_BIT       = 30;  // 1 = last descriptor of the ring
    localparam int EOF_BIT        = 15;  // 1 = buffer ends a frame
    localparam int CTRL_EN_BIT    = 3;   // transmit enable
    localparam int CTRL_START_BIT = 9;   // start command (write-one)
    localparam int FLAGS_OFS      = 4;   // flags word offset in a descriptor
    localparam int DESC_BYTES     = 8;   // descriptor stride

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_FL_REQ,
        SQ_FL_WAIT,
        SQ_AD_REQ,
        SQ_AD_WAIT,
        SQ_DW_REQ,
        SQ_DW_WAIT,
        SQ_SEND,
        SQ_WB
    } seq_state_t;
endpackage

// File: rtl/txr_regs.sv
// Module: control and queue-base registers.
// Holds the enable bit and the ring base address, and turns a control write
// with both start and enable set into a one-cycle start pulse.
// Assumes the base address written by software is 8-byte aligned.
module txr_regs
    import txr_pkg::*;
#(
    parameter int                AW       = 32,
    parameter int                REG_AW   = 8,
    parameter logic [REG_AW-1:0] CTRL_OFS = 'h00,
    parameter logic [REG_AW-1:0] BASE_OFS = 'h1C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic              en,
    output logic [AW-1:0]     base,
    output logic              start
);
    logic ctrl_hit;
    logic base_hit;

    assign ctrl_hit = reg_we && (reg_addr == CTRL_OFS);
    assign base_hit = reg_we && (reg_addr == BASE_OFS);

    // Control register: enable level and start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en    <= 1'b0;
            start <= 1'b0;
        end else begin
            start <= 1'b0;
            if (ctrl_hit) begin
                en    <= reg_wdata[CTRL_EN_BIT];
                start <= reg_wdata[CTRL_START_BIT] && reg_wdata[CTRL_EN_BIT];
            end
        end
    end

    // Queue base register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base <= '0;
        end else if (base_hit) begin
            base <= reg_wdata[AW-1:0];
        end
    end
endmodule

// File: rtl/txr_seq.sv
// Module: descriptor walker and memory port master.
// Fetches the flags word, then the buffer address, then the buffer words, and
// finally writes the flags back with the ownership bit set. It follows the
// wrap bit and parks on a software-owned descriptor.
// Assumes one read outstanding at a time, word-aligned buffers and a read
// response that comes at least one cycle after acceptance.
module txr_seq
    import txr_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LEN_W = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [AW-1:0] base,
    input  logic          start,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ready,
    input  logic          mem_rvalid,
    input  logic [31:0]   mem_rdata,
    output logic          ser_load,
    output logic [31:0]   ser_word,
    output logic [2:0]    ser_nbytes,
    output logic          ser_eof,
    output logic          ser_flush,
    input  logic          ser_done,
    output logic [AW-1:0] desc_ptr_o
);
    localparam logic [LEN_W-1:0] WORD_BYTES = LEN_W'(4);

    seq_state_t       state;
    logic [AW-1:0]    desc_ptr;
    logic [AW-1:0]    buf_ptr;
    logic [LEN_W-1:0] rem;
    logic [31:0]      flags;
    logic             kick;
    logic             rd_pend;
    logic             last_word;
    logic             owned_in;
    logic             rd_accept;

    assign last_word  = (rem <= WORD_BYTES);
    assign owned_in   = mem_rdata[OWN_BIT];
    assign rd_accept  = mem_req && mem_ready && !mem_we;
    assign desc_ptr_o = desc_ptr;

    // Memory request signals decoded from the walker state.
    always_comb begin
        mem_req   = (state == SQ_FL_REQ) || (state == SQ_AD_REQ) ||
                    (state == SQ_DW_REQ) || (state == SQ_WB);
        mem_we    = (state == SQ_WB);
        mem_wdata = flags | (32'd1 << OWN_BIT);
        case (state)
            SQ_FL_REQ, SQ_WB: mem_addr = desc_ptr + AW'(FLAGS_OFS);
            SQ_DW_REQ:        mem_addr = buf_ptr;
            default:          mem_addr = desc_ptr;
        endcase
    end

    // Serializer loading: one buffer word per read response.
    always_comb begin
        ser_load   = (state == SQ_DW_WAIT) && mem_rvalid;
        ser_word   = mem_rdata;
        ser_nbytes = last_word ? rem[2:0] : 3'd4;
        ser_eof    = flags[EOF_BIT] && last_word;
        ser_flush  = !en;
    end

    // Pending start: set by a start command, consumed on leaving idle or
    // by one re-read of a software-owned descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            kick <= 1'b0;
        end else if (start) begin
            kick <= 1'b1;
        end else if ((state == SQ_IDLE && !rd_pend) ||
                     (state == SQ_FL_WAIT && mem_rvalid && owned_in)) begin
            kick <= 1'b0;
        end
    end

    // Outstanding read tracker, so a stale response after an abort is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend <= 1'b0;
        end else if (rd_accept) begin
            rd_pend <= 1'b1;
        end else if (mem_rvalid) begin
            rd_pend <= 1'b0;
        end
    end

    // Walker state machine and ring pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            desc_ptr <= '0;
            buf_ptr  <= '0;
            rem      <= '0;
            flags    <= '0;
        end else if (!en) begin
            state    <= SQ_IDLE;
            desc_ptr <= base;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (kick && !rd_pend) state <= SQ_FL_REQ;
                end
                SQ_FL_REQ: begin
                    if (mem_ready) state <= SQ_FL_WAIT;
                end
                SQ_FL_WAIT: begin
                    if (mem_rvalid) begin
                        flags <= mem_rdata;
                        if (owned_in) state <= kick ? SQ_FL_REQ : SQ_IDLE;
                        else          state <= SQ_AD_REQ;
                    end
                end
                SQ_AD_REQ: begin
                    if (mem_ready) state <= SQ_AD_WAIT;
                end
                SQ_AD_WAIT: begin
                    if (mem_rvalid) begin
                        buf_ptr <= mem_rdata[AW-1:0];
                        rem     <= flags[LEN_W-1:0];
                        state   <= (flags[LEN_W-1:0] == '0) ? SQ_WB : SQ_DW_REQ;
                    end
                end
                SQ_DW_REQ: begin
                    if (mem_ready) state <= SQ_DW_WAIT;
                end
                SQ_DW_WAIT: begin
                    if (mem_rvalid) state <= SQ_SEND;
                end
                SQ_SEND: begin
                    if (ser_done) begin
                        if (last_word) begin
                            rem   <= '0;
                            state <= SQ_WB;
                        end else begin
                            rem     <= rem - WORD_BYTES;
                            buf_ptr <= buf_ptr + AW'(4);
                            state   <= SQ_DW_REQ;
                        end
                    end
                end
                SQ_WB: begin
                    if (mem_ready) begin
                        desc_ptr <= flags[WRAP_BIT] ? base : desc_ptr + AW'(DESC_BYTES);
                        state    <= SQ_FL_REQ;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/txr_bytes.sv
// Module: word-to-byte serializer for the outgoing stream.
// Takes a 32-bit little-endian word with a byte count of 1 to 4 and emits the
// bytes lowest first. It marks the final byte when the word ends a frame.
// Assumes a new word is loaded only after done has been raised for the last.
module txr_bytes (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [31:0] word,
    input  logic [2:0]  nbytes,
    input  logic        eof,
    input  logic        flush,
    input  logic        tx_ready,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    output logic        done
);
    logic [31:0] sh;
    logic [2:0]  cnt;
    logic        eof_q;

    assign tx_valid = (cnt != 3'd0);
    assign tx_data  = sh[7:0];
    assign tx_last  = eof_q && (cnt == 3'd1);
    assign done     = tx_valid && tx_ready && (cnt == 3'd1);

    // Shift register and remaining byte count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh    <= '0;
            cnt   <= '0;
            eof_q <= 1'b0;
        end else if (flush) begin
            cnt <= '0;
        end else if (load) begin
            sh    <= word;
            cnt   <= nbytes;
            eof_q <= eof;
        end else if (tx_valid && tx_ready) begin
            sh  <= {8'd0, sh[31:8]};
            cnt <= cnt - 3'd1;
        end
    end
endmodule

// File: rtl/txr_dma.sv
// Module: transmit descriptor ring engine, top level.
// Connects the register file, the descriptor walker and the byte serializer.
// Assumes LEN_W lies between 3 and 15 so the length stays below the frame-end
// bit, and AW is at most 32.
module txr_dma #(
    parameter int                AW       = 32,
    parameter int                LEN_W    = 14,
    parameter int                REG_AW   = 8,
    parameter logic [REG_AW-1:0] CTRL_OFS = 'h00,
    parameter logic [REG_AW-1:0] BASE_OFS = 'h1C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready
);
    logic          en_q;
    logic [AW-1:0] base_q;
    logic          start_q;
    logic          ser_load;
    logic [31:0]   ser_word;
    logic [2:0]    ser_nbytes;
    logic          ser_eof;
    logic          ser_flush;
    logic          ser_done;
    logic [AW-1:0] desc_ptr_w;

    txr_regs #(
        .AW(AW), .REG_AW(REG_AW), .CTRL_OFS(CTRL_OFS), .BASE_OFS(BASE_OFS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .en(en_q), .base(base_q), .start(start_q)
    );

    txr_seq #(.AW(AW), .LEN_W(LEN_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .en(en_q), .base(base_q), .start(start_q),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .ser_load(ser_load), .ser_word(ser_word),
        .ser_nbytes(ser_nbytes), .ser_eof(ser_eof), .ser_flush(ser_flush),
        .ser_done(ser_done), .desc_ptr_o(desc_ptr_w)
    );

    txr_bytes u_bytes (
        .clk(clk), .rst_n(rst_n), .load(ser_load), .word(ser_word),
        .nbytes(ser_nbytes), .eof(ser_eof), .flush(ser_flush),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_last(tx_last), .done(ser_done)
    );
endmodule

// File: rtl/txr_dma_checker.sv
// Module: protocol and ring-pointer assertions for txr_dma, bound to the top.
// Assumes it sees the enable, base and descriptor pointer nets of the top.
module txr_dma_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic [AW-1:0] base,
    input logic [AW-1:0] desc_ptr,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          mem_ready,
    input logic          tx_valid,
    input logic [7:0]    tx_data,
    input logic          tx_last,
    input logic          tx_ready
);
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!mem_req && !tx_valid));  // R1

    AST_PTR_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (desc_ptr == $past(base)));  // R10

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !en)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) &&
                                     $stable(mem_we) && $stable(mem_wdata)));  // R12

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !en)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));  // R12

    AST_WB_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[31] && (mem_addr[2:0] == 3'd4)));  // R6

    AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);  // R5
endmodule

bind txr_dma txr_dma_checker #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en_q), .base(base_q), .desc_ptr(desc_ptr_w),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
);

// File: tb/txr_dma_test.sv
module txr_dma_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        mem_req, mem_we, mem_ready, mem_rvalid;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        tx_valid, tx_last, tx_ready;
    logic [7:0]  tx_data;

    int nchk = 0;
    int nerr = 0;

    // memory model and logs
    logic [31:0] mem [0:255];
    logic        tb_we = 1'b0;
    logic [7:0]  tb_idx = '0;
    logic [31:0] tb_data = '0;
    logic        log_clr = 1'b0;
    logic [31:0] watch_addr = '0;
    logic [31:0] cyc = '0;
    logic        r1_v;
    logic [31:0] r1_d;
    logic [7:0]  blog [0:127];
    logic        llog [0:127];
    int          nb;
    logic        got_first;
    logic [31:0] first_addr;
    int          watch_cnt;

    always #10 clk = ~clk;

    assign mem_ready = (cyc[1:0] != 2'd3);
    assign tx_ready  = (cyc[2:0] != 3'd5);

    txr_dma uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
    );

    always @(posedge clk) begin
        cyc <= cyc + 32'd1;
        if (tb_we) mem[tb_idx] <= tb_data;
        if (mem_req && mem_ready && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        r1_v       <= mem_req && mem_ready && !mem_we;
        r1_d       <= mem[mem_addr[9:2]];
        mem_rvalid <= r1_v;
        mem_rdata  <= r1_d;
        if (log_clr) begin
            nb        <= 0;
            got_first <= 1'b0;
            watch_cnt <= 0;
        end else begin
            if (tx_valid && tx_ready && nb < 128) begin
                blog[nb] <= tx_data;
                llog[nb] <= tx_last;
                nb       <= nb + 1;
            end
            if (mem_req && mem_ready && !mem_we) begin
                if (!got_first) begin
                    got_first  <= 1'b1;
                    first_addr <= mem_addr;
                end
                if (mem_addr == watch_addr) watch_cnt <= watch_cnt + 1;
            end
        end
    end

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_word(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_idx = a[9:2]; tb_data = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic write_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic clear_log();
        @(negedge clk);
        log_clr = 1'b1;
        @(negedge clk);
        log_clr = 1'b0;
    endtask

    task automatic put_desc(input logic [31:0] d, input logic [31:0] b, input logic [31:0] f);
        set_word(d, b);
        set_word(d + 4, f);
    endtask

    task automatic fill_buf(input logic [31:0] a, input int n, input logic [7:0] seed);
        for (int w = 0; w < (n + 3) / 4; w++) begin
            logic [31:0] v;
            for (int k = 0; k < 4; k++) v[8*k +: 8] = seed + 8'(4 * w + k);
            set_word(a + 32'(4 * w), v);
        end
    endtask

    // compare logged bytes [st, st+n) against seed+i
    task automatic check_bytes(input int st, input int n, input logic [7:0] seed, input string rq);
        int bad = 0;
        int first_bad = -1;
        for (int i = 0; i < n; i++) begin
            if (blog[st + i] !== seed + 8'(i)) begin
                bad++;
                if (first_bad < 0) first_bad = i;
            end
        end
        check(bad == 0, rq, (first_bad < 0) ? 0 : int'(blog[st + first_bad]),
              (first_bad < 0) ? 0 : int'(seed + 8'(first_bad)));
    endtask

    task automatic count_last(output int c);
        c = 0;
        for (int i = 0; i < nb; i++) if (llog[i]) c++;
    endtask

    // R1 R13 R14: quiet after reset and after ignored writes
    task automatic t_reset();
        check(!mem_req && !tx_valid, "R1 reset quiet", {mem_req, tx_valid}, 0);
        write_reg(8'h10, 32'h0000_0208);
        run(20);
        check(!got_first && nb == 0, "R13 unknown offset ignored", nb, 0);
        write_reg(8'h00, 32'h0000_0200);
        run(20);
        check(!got_first && nb == 0, "R14 start without enable ignored", nb, 0);
        check(!mem_req && !tx_valid, "R1 still quiet while disabled", {mem_req, tx_valid}, 0);
    endtask

    // R2 R3 R4 R5 R6 R8: two single-buffer frames then an owned descriptor
    task automatic t_basic();
        int c;
        write_reg(8'h1C, 32'h100);
        fill_buf(32'h200, 6, 8'h10);
        fill_buf(32'h240, 9, 8'h20);
        put_desc(32'h100, 32'h200, 32'h0000_8006);
        put_desc(32'h108, 32'h240, 32'h0000_8009);
        put_desc(32'h110, 32'h280, 32'h8000_0000);
        watch_addr = 32'h114;
        clear_log();
        write_reg(8'h00, 32'h0000_0208);
        run(200);
        check(first_addr == 32'h104, "R2 first read is base flags", first_addr, 32'h104);
        check(nb == 15, "R8 both descriptors sent", nb, 15);
        check_bytes(0, 6, 8'h10, "R4 first buffer bytes");
        check_bytes(6, 9, 8'h20, "R4 second buffer bytes");
        count_last(c);
        check(c == 2 && llog[5] && llog[14], "R5 last on frame ends", c, 2);
        check(mem[8'h41] == 32'h8000_8006, "R6 write-back desc0", mem[8'h41], 32'h8000_8006);
        check(mem[8'h43] == 32'h8000_8009, "R6 write-back desc1", mem[8'h43], 32'h8000_8009);
        check(mem[8'h45] == 32'h8000_0000 && watch_cnt == 1, "R3 owned desc untouched",
              watch_cnt, 1);
    endtask

    // R5 R7: two-buffer frame ending on the wrap descriptor
    task automatic t_multibuf();
        int c;
        fill_buf(32'h280, 3, 8'h40);
        fill_buf(32'h2C0, 5, 8'h60);
        put_desc(32'h118, 32'h2C0, 32'h4000_8005);
        put_desc(32'h110, 32'h280, 32'h0000_0003);
        watch_addr = 32'h104;
        clear_log();
        write_reg(8'h00, 32'h0000_0208);
        run(200);
        check(first_addr == 32'h114, "R2 resume at parked descriptor", first_addr, 32'h114);
        check(nb == 8, "R4 multi-buffer byte count", nb, 8);
        check_bytes(0, 3, 8'h40, "R4 first part");
        check_bytes(3, 5, 8'h60, "R4 second part");
        count_last(c);
        check(c == 1 && llog[7], "R5 single last on final byte", c, 1);
        check(watch_cnt == 1, "R7 wrap goes back to base", watch_cnt, 1);
        check(mem[8'h47] == 32'hC000_8005, "R6 wrap desc written back", mem[8'h47], 32'hC000_8005);
    endtask

    // R7: after the wrap the next start begins at the base
    task automatic t_wrap();
        fill_buf(32'h300, 4, 8'h90);
        put_desc(32'h100, 32'h300, 32'h0000_8004);
        clear_log();
        write_reg(8'h00, 32'h0000_0208);
        run(120);
        check(first_addr == 32'h104, "R7 pointer at base after wrap", first_addr, 32'h104);
        check(nb == 4, "R7 base descriptor sent", nb, 4);
        check_bytes(0, 4, 8'h90, "R4 base descriptor bytes");
    endtask

    // R11: zero-length descriptor
    task automatic t_zero();
        put_desc(32'h108, 32'h380, 32'h0000_8000);
        clear_log();
        write_reg(8'h00, 32'h0000_0208);
        run(80);
        check(nb == 0, "R11 no bytes for zero length", nb, 0);
        check(mem[8'h43] == 32'h8000_8000, "R11 zero length written back", mem[8'h43], 32'h8000_8000);
    endtask

    // R9 R12: start while busy causes one re-read of the owned descriptor
    task automatic t_kick();
        fill_buf(32'h340, 40, 8'hA0);
        put_desc(32'h110, 32'h340, 32'h0000_8028);
        watch_addr = 32'h11C;
        clear_log();
        write_reg(8'h00, 32'h0000_0208);
        run(10);
        write_reg(8'h00, 32'h0000_0208);
        run(400);
        check(watch_cnt == 2, "R9 held start re-reads owned descriptor", watch_cnt, 2);
        check(nb == 40, "R12 all bytes under back-pressure", nb, 40);
        check_bytes(0, 40, 8'hA0, "R12 byte stream intact under stalls");
    endtask

    // R10: abort mid-frame, no write-back, pointer back to base
    task automatic t_abort();
        put_desc(32'h118, 32'h340, 32'h4000_8028);
        clear_log();
        write_reg(8'h00, 32'h0000_0208);
        run(25);
        write_reg(8'h00, 32'h0000_0000);
        run(3);
        check(!tx_valid && !mem_req, "R10 quiet after disable", {tx_valid, mem_req}, 0);
        run(30);
        check(mem[8'h47] == 32'h4000_8028, "R10 no write-back on abort", mem[8'h47], 32'h4000_8028);
        check(nb < 40, "R10 frame truncated", nb, 39);
        fill_buf(32'h300, 4, 8'hC0);
        put_desc(32'h100, 32'h300, 32'h0000_8004);
        clear_log();
        write_reg(8'h00, 32'h0000_0208);
        run(120);
        check(first_addr == 32'h104, "R10 restart at base", first_addr, 32'h104);
        check(nb == 4 && llog[3], "R10 restarted frame complete", nb, 4);
        check_bytes(0, 4, 8'hC0, "R4 restarted frame bytes");
    endtask

    initial begin
        bit timed_out = 1'b0;
        log_clr = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        log_clr = 1'b0;
        @(negedge clk);
        fork
            begin
                t_reset();
                t_basic();
                t_multibuf();
                t_wrap();
                t_zero();
                t_kick();
                t_abort();
            end
            begin
                repeat (100000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) check(1'b0, "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule